// File: doc/BRIEF.md
# Two-Level Page Translation Buffer with Victim Store

This block turns virtual addresses into physical page numbers for a fixed 512 KB page size. A lookup is first tried in a small fully associative front array (16 entries, true LRU). It is then tried in a larger second array of 8 sets by 8 ways with tree pseudo-LRU. Last, it is tried in an 8-entry victim store that catches whatever the second array throws out. Each response reports where the translation was found and a latency class that models how long a real access would take. That class is about 441 cycles from the front array, 50 more from the second array and a few more again from the victim store. A complete miss is about 700 cycles.

When all three structures miss, the block raises a walk request and stops taking new lookups. It waits in that state until the page walker returns a fill, which is written into both arrays. A hit in the second array copies the entry forward into the front array. A victim hit moves the entry back into both arrays and out of the victim store. A single flush pulse empties all three structures.

The controller has two states. `ST_LOOKUP` accepts requests. It moves to `ST_WALK` when a request misses everywhere. `ST_WALK` holds the walk request. It returns to `ST_LOOKUP` in the cycle a fill is presented. No other transition exists.

Top module: `tlb_two_level`

## Requirements
- R1: The page number is address bits 31 down to 19. The low 19 bits never change the result, and addresses that differ only in bit 19 are separate pages.
- R2: One cycle after a request is accepted, resp_valid is high and the response carries a level code, a page number and a latency class. The level codes are 0 for the front array, 1 for the second array, 2 for the victim store and 3 for a miss. The page number is the installed mapping. The latency classes are 441, 491, 495 and 700. A page that has just been filled hits the front array.
- R3: On a miss, walk_req_valid is high in the same cycle as the miss response and carries the page number. It stays high with a stable page number, and req_ready stays low, until a fill is presented. req_ready is high again in the next cycle.
- R4: The front array holds 16 entries. When it is full, a new entry replaces the least recently used one, and that page is then found in the second array.
- R5: A hit in the second array copies the entry into the front array, so the next lookup of that page reports level 0.
- R6: The second-array set index is page-number bits 2 to 0. Replacement takes the lowest invalid way. Otherwise it takes the way that the set's binary tree points to; each access turns the tree bits on its path away from the accessed way. An evicted valid entry enters the victim store. A victim hit reports level 2 and moves the entry back into the second array and the front array.
- R7: The victim store keeps 8 entries in FIFO order. A ninth eviction overwrites the oldest one, and that page then misses.
- R8: A flush pulse invalidates every entry of all three structures in one cycle.
- R9: A fill presented while no walk is outstanding is ignored.
- R10: After reset, req_ready is high, and resp_valid and walk_req_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate every entry |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | 32 | Virtual address of the lookup |
| req_ready | output | 1 | High when a request can be taken |
| resp_valid | output | 1 | Response present |
| resp_level | output | 2 | 0 front, 1 second, 2 victim, 3 miss |
| resp_ppn | output | 13 | Physical page number |
| resp_lat | output | 10 | Modelled latency class in cycles |
| walk_req_valid | output | 1 | Walk outstanding |
| walk_vpn | output | 13 | Page number to walk |
| fill_valid | input | 1 | Fill from the walker |
| fill_vpn | input | 13 | Page number of the fill |
| fill_ppn | input | 13 | Physical page number of the fill |

## Verification
Directed sequences first fill the front array with seventeen pages, which separates true LRU from any other front-array policy. Nine and then seventeen pages aimed at one set show the tree victim choice, the return path from the victim store and the FIFO overwrite. Tests with other offsets and with neighbouring pages show that only the upper address bits select a translation. Random traffic is confined to two crowded sets and mixed with occasional flushes. It tells stale or wrong page numbers apart from correct ones, because no page the bench has not filled may ever hit, and each latency class must match its level.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    typedef enum logic [1:0] {
        LVL_L1   = 2'd0,
        LVL_L2   = 2'd1,
        LVL_VB   = 2'd2,
        LVL_MISS = 2'd3
    } tlb_level_e;

    typedef enum logic {
        ST_LOOKUP = 1'b0,
        ST_WALK   = 1'b1
    } tlb_state_e;
endpackage

// File: rtl/tlb_front_assoc.sv
module tlb_front_assoc #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 13,
    parameter int PPN_W   = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn,
    input  logic             touch_en,
    input  logic             ins_en,
    input  logic [VPN_W-1:0] ins_vpn,
    input  logic [PPN_W-1:0] ins_ppn
);
    localparam int IDX_W = $clog2(ENTRIES);

    logic [ENTRIES-1:0] valid_q;
    logic [VPN_W-1:0]   vpn_q [ENTRIES];
    logic [PPN_W-1:0]   ppn_q [ENTRIES];
    logic [IDX_W-1:0]   age_q [ENTRIES];
    logic [ENTRIES-1:0] match;
    logic [IDX_W-1:0]   hit_idx, repl_idx, upd_idx;
    logic               have_free, upd_en;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = valid_q[g] && (vpn_q[g] == lk_vpn);
    end

    assign lk_hit = |match;

    always_comb begin
        hit_idx = '0;
        lk_ppn  = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) begin
                hit_idx = IDX_W'(i);
                lk_ppn  = ppn_q[i];
            end
        end
    end

    always_comb begin
        repl_idx  = '0;
        have_free = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_q[i]) begin
                have_free = 1'b1;
                repl_idx  = IDX_W'(i);
            end
        end
        if (!have_free) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (age_q[i] == IDX_W'(ENTRIES - 1)) repl_idx = IDX_W'(i);
            end
        end
    end

    assign upd_idx = ins_en ? repl_idx : hit_idx;
    assign upd_en  = ins_en || (touch_en && lk_hit);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                vpn_q[i] <= '0;
                ppn_q[i] <= '0;
                age_q[i] <= IDX_W'(i);
            end
        end else if (flush) begin
            valid_q <= '0;
        end else begin
            if (ins_en) begin
                valid_q[repl_idx] <= 1'b1;
                vpn_q[repl_idx]   <= ins_vpn;
                ppn_q[repl_idx]   <= ins_ppn;
            end
            if (upd_en) begin
                for (int i = 0; i < ENTRIES; i++) begin
                    if (IDX_W'(i) == upd_idx) age_q[i] <= '0;
                    else if (age_q[i] < age_q[upd_idx]) age_q[i] <= age_q[i] + 1'b1;
                end
            end
        end
    end

    assert_flush_empties_R8 : assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_q == '0));

    assert_one_update_R4 : assert property (@(posedge clk) disable iff (!rst_n)
        ins_en |-> !touch_en);
endmodule

// File: rtl/tlb_second_setassoc.sv
module tlb_second_setassoc #(
    parameter int SETS  = 8,
    parameter int WAYS  = 8,
    parameter int VPN_W = 13,
    parameter int PPN_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn,
    input  logic             touch_en,
    input  logic             ins_en,
    input  logic [VPN_W-1:0] ins_vpn,
    input  logic [PPN_W-1:0] ins_ppn,
    output logic             ev_valid,
    output logic [VPN_W-1:0] ev_vpn,
    output logic [PPN_W-1:0] ev_ppn
);
    localparam int SET_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);

    logic [WAYS-1:0]  valid_q [SETS];
    logic [VPN_W-1:0] vpn_q   [SETS][WAYS];
    logic [PPN_W-1:0] ppn_q   [SETS][WAYS];
    logic [WAYS-1:0]  tree_q  [SETS];

    logic [SET_W-1:0] lk_set, ins_set;
    logic [WAY_W-1:0] hit_way, ins_way;
    logic [WAYS-1:0]  match;
    logic             set_full;

    function automatic logic [WAY_W-1:0] tree_pick(input logic [WAYS-1:0] bits);
        int n;
        n = 1;
        for (int l = 0; l < WAY_W; l++) n = 2 * n + (bits[WAY_W'(n)] ? 1 : 0);
        return WAY_W'(n - WAYS);
    endfunction

    function automatic logic [WAYS-1:0] tree_touch(input logic [WAYS-1:0] bits,
                                                   input logic [WAY_W-1:0] way);
        logic [WAYS-1:0] r;
        int n, p;
        r = bits;
        n = int'(way) + WAYS;
        for (int l = 0; l < WAY_W; l++) begin
            p = n / 2;
            r[WAY_W'(p)] = ((n % 2) == 0);
            n = p;
        end
        return r;
    endfunction

    assign lk_set  = lk_vpn[SET_W-1:0];
    assign ins_set = ins_vpn[SET_W-1:0];

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign match[w] = valid_q[lk_set][w] && (vpn_q[lk_set][w] == lk_vpn);
    end

    assign lk_hit = |match;

    always_comb begin
        hit_way = '0;
        lk_ppn  = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w]) begin
                hit_way = WAY_W'(w);
                lk_ppn  = ppn_q[lk_set][w];
            end
        end
    end

    always_comb begin
        set_full = &valid_q[ins_set];
        ins_way  = tree_pick(tree_q[ins_set]);
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid_q[ins_set][w]) ins_way = WAY_W'(w);
        end
    end

    assign ev_valid = ins_en && valid_q[ins_set][ins_way];
    assign ev_vpn   = vpn_q[ins_set][ins_way];
    assign ev_ppn   = ppn_q[ins_set][ins_way];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                tree_q[s]  <= '0;
                for (int w = 0; w < WAYS; w++) begin
                    vpn_q[s][w] <= '0;
                    ppn_q[s][w] <= '0;
                end
            end
        end else if (flush) begin
            for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
        end else if (ins_en) begin
            valid_q[ins_set][ins_way] <= 1'b1;
            vpn_q[ins_set][ins_way]   <= ins_vpn;
            ppn_q[ins_set][ins_way]   <= ins_ppn;
            tree_q[ins_set]           <= tree_touch(tree_q[ins_set], ins_way);
        end else if (touch_en && lk_hit) begin
            tree_q[lk_set] <= tree_touch(tree_q[lk_set], hit_way);
        end
    end

    assert_evict_only_full_R6 : assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid |-> set_full);

    assert_one_update_R5 : assert property (@(posedge clk) disable iff (!rst_n)
        ins_en |-> !touch_en);
endmodule

// File: rtl/tlb_victim_fifo.sv
module tlb_victim_fifo #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 13,
    parameter int PPN_W   = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn,
    input  logic             rm_en,
    input  logic             push_en,
    input  logic [VPN_W-1:0] push_vpn,
    input  logic [PPN_W-1:0] push_ppn
);
    localparam int PTR_W = $clog2(ENTRIES);

    logic [ENTRIES-1:0] valid_q;
    logic [VPN_W-1:0]   vpn_q [ENTRIES];
    logic [PPN_W-1:0]   ppn_q [ENTRIES];
    logic [PTR_W-1:0]   wr_ptr_q, hit_idx;
    logic [ENTRIES-1:0] match;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = valid_q[g] && (vpn_q[g] == lk_vpn);
    end

    assign lk_hit = |match;

    always_comb begin
        hit_idx = '0;
        lk_ppn  = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) begin
                hit_idx = PTR_W'(i);
                lk_ppn  = ppn_q[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q  <= '0;
            wr_ptr_q <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                vpn_q[i] <= '0;
                ppn_q[i] <= '0;
            end
        end else if (flush) begin
            valid_q  <= '0;
            wr_ptr_q <= '0;
        end else begin
            if (rm_en && lk_hit) valid_q[hit_idx] <= 1'b0;
            if (push_en) begin
                valid_q[wr_ptr_q] <= 1'b1;
                vpn_q[wr_ptr_q]   <= push_vpn;
                ppn_q[wr_ptr_q]   <= push_ppn;
                wr_ptr_q <= (wr_ptr_q == PTR_W'(ENTRIES - 1)) ? '0 : wr_ptr_q + 1'b1;
            end
        end
    end

    assert_remove_needs_hit_R6 : assert property (@(posedge clk) disable iff (!rst_n)
        rm_en |-> lk_hit);

    assert_single_match_R7 : assert property (@(posedge clk) disable iff (!rst_n)
        $countones(match) <= 1);
endmodule

// File: rtl/tlb_two_level.sv
module tlb_two_level
    import tlb_pkg::*;
#(
    parameter int VA_W       = 32,
    parameter int PAGE_SHIFT = 19,
    parameter int PPN_W      = 13,
    parameter int L1_ENTRIES = 16,
    parameter int L2_SETS    = 8,
    parameter int L2_WAYS    = 8,
    parameter int VB_ENTRIES = 8,
    parameter int LAT_W      = 10,
    parameter int LAT_L1     = 441,
    parameter int LAT_L2     = 491,
    parameter int LAT_VB     = 495,
    parameter int LAT_MISS   = 700,
    localparam int VPN_W     = VA_W - PAGE_SHIFT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_vaddr,
    output logic             req_ready,
    output logic             resp_valid,
    output logic [1:0]       resp_level,
    output logic [PPN_W-1:0] resp_ppn,
    output logic [LAT_W-1:0] resp_lat,
    output logic             walk_req_valid,
    output logic [VPN_W-1:0] walk_vpn,
    input  logic             fill_valid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn
);
    tlb_state_e st_q, st_d;

    logic [VPN_W-1:0] req_vpn, ins_vpn;
    logic [PPN_W-1:0] ins_ppn;
    logic             accept;
    logic             l1_hit, l2_hit, vb_hit;
    logic [PPN_W-1:0] l1_ppn, l2_ppn, vb_ppn;
    logic             l1_touch, l1_ins, l2_touch, l2_ins, vb_rm;
    logic             ev_valid;
    logic [VPN_W-1:0] ev_vpn;
    logic [PPN_W-1:0] ev_ppn;
    logic             unused_offset;

    assign req_vpn        = req_vaddr[VA_W-1:PAGE_SHIFT];
    assign unused_offset  = ^req_vaddr[PAGE_SHIFT-1:0];
    assign accept         = (st_q == ST_LOOKUP) && req_valid;
    assign req_ready      = (st_q == ST_LOOKUP);
    assign walk_req_valid = (st_q == ST_WALK);

    tlb_front_assoc #(.ENTRIES(L1_ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_front (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .lk_vpn(req_vpn), .lk_hit(l1_hit), .lk_ppn(l1_ppn),
        .touch_en(l1_touch), .ins_en(l1_ins), .ins_vpn(ins_vpn), .ins_ppn(ins_ppn)
    );

    tlb_second_setassoc #(.SETS(L2_SETS), .WAYS(L2_WAYS), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_second (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .lk_vpn(req_vpn), .lk_hit(l2_hit), .lk_ppn(l2_ppn),
        .touch_en(l2_touch), .ins_en(l2_ins), .ins_vpn(ins_vpn), .ins_ppn(ins_ppn),
        .ev_valid(ev_valid), .ev_vpn(ev_vpn), .ev_ppn(ev_ppn)
    );

    tlb_victim_fifo #(.ENTRIES(VB_ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_victim (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .lk_vpn(req_vpn), .lk_hit(vb_hit), .lk_ppn(vb_ppn),
        .rm_en(vb_rm), .push_en(ev_valid), .push_vpn(ev_vpn), .push_ppn(ev_ppn)
    );

    always_comb begin
        st_d     = st_q;
        l1_touch = 1'b0;
        l1_ins   = 1'b0;
        l2_touch = 1'b0;
        l2_ins   = 1'b0;
        vb_rm    = 1'b0;
        ins_vpn  = req_vpn;
        ins_ppn  = l2_ppn;
        unique case (st_q)
            ST_LOOKUP: begin
                if (req_valid) begin
                    if (l1_hit) begin
                        l1_touch = 1'b1;
                    end else if (l2_hit) begin
                        l2_touch = 1'b1;
                        l1_ins   = 1'b1;
                    end else if (vb_hit) begin
                        vb_rm   = 1'b1;
                        l2_ins  = 1'b1;
                        l1_ins  = 1'b1;
                        ins_ppn = vb_ppn;
                    end else begin
                        st_d = ST_WALK;
                    end
                end
            end
            ST_WALK: begin
                if (fill_valid) begin
                    l1_ins  = 1'b1;
                    l2_ins  = 1'b1;
                    ins_vpn = fill_vpn;
                    ins_ppn = fill_ppn;
                    st_d    = ST_LOOKUP;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_LOOKUP;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_level <= LVL_MISS;
            resp_ppn   <= '0;
            resp_lat   <= '0;
            walk_vpn   <= '0;
        end else begin
            resp_valid <= accept;
            if (accept) begin
                if (l1_hit) begin
                    resp_level <= LVL_L1;
                    resp_ppn   <= l1_ppn;
                    resp_lat   <= LAT_W'(LAT_L1);
                end else if (l2_hit) begin
                    resp_level <= LVL_L2;
                    resp_ppn   <= l2_ppn;
                    resp_lat   <= LAT_W'(LAT_L2);
                end else if (vb_hit) begin
                    resp_level <= LVL_VB;
                    resp_ppn   <= vb_ppn;
                    resp_lat   <= LAT_W'(LAT_VB);
                end else begin
                    resp_level <= LVL_MISS;
                    resp_ppn   <= '0;
                    resp_lat   <= LAT_W'(LAT_MISS);
                    walk_vpn   <= req_vpn;
                end
            end
        end
    end

    assert_walk_held_R3 : assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req_valid && !fill_valid) |=> (walk_req_valid && $stable(walk_vpn)));

    assert_miss_opens_walk_R3 : assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_level == LVL_MISS) |-> walk_req_valid);

    assert_backing_exclusive_R6 : assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> ($countones({l2_hit, vb_hit}) <= 1));

    assert_fill_idle_ignored_R9 : assert property (@(posedge clk) disable iff (!rst_n || flush)
        (st_q == ST_LOOKUP && !req_valid) |=> (st_q == ST_LOOKUP));
endmodule

// File: tb/tlb_two_level_test.sv
module tlb_two_level_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_ready;
    logic        resp_valid;
    logic [1:0]  resp_level;
    logic [12:0] resp_ppn;
    logic [9:0]  resp_lat;
    logic        walk_req_valid;
    logic [12:0] walk_vpn;
    logic        fill_valid = 1'b0;
    logic [12:0] fill_vpn = '0;
    logic [12:0] fill_ppn = '0;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 1'b0;
    bit  mapped [0:255];

    always #4 clk = ~clk;

    tlb_two_level uut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_ready(req_ready),
        .resp_valid(resp_valid), .resp_level(resp_level), .resp_ppn(resp_ppn), .resp_lat(resp_lat),
        .walk_req_valid(walk_req_valid), .walk_vpn(walk_vpn),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn)
    );

    function automatic int pmap(input int vpn);
        return (vpn * 37 + 11) & 32'h1FFF;
    endfunction

    function automatic int lat_of(input int lvl);
        case (lvl)
            0:       return 441;
            1:       return 491;
            2:       return 495;
            default: return 700;
        endcase
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        for (int i = 0; i < 256; i++) mapped[i] = 1'b0;
    endtask

    task automatic access(input int vpn, input int exp_lvl, input string req, output int lvl);
        int ppn, lat;
        @(negedge clk);
        chk(req, "req_ready before request", int'(req_ready), 1);
        req_valid = 1'b1;
        req_vaddr = {13'(vpn), 19'($urandom)};
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2", "resp_valid", int'(resp_valid), 1);
        lvl = int'(resp_level);
        ppn = int'(resp_ppn);
        lat = int'(resp_lat);
        if (exp_lvl >= 0) chk(req, "level", lvl, exp_lvl);
        chk("R2", "latency class", lat, lat_of(lvl));
        if (lvl != 3) begin
            chk("R2", "ppn", ppn, pmap(vpn));
        end else begin
            chk("R3", "walk_req_valid", int'(walk_req_valid), 1);
            chk("R3", "walk_vpn", int'(walk_vpn), vpn);
            chk("R3", "req_ready during walk", int'(req_ready), 0);
            @(negedge clk);
            chk("R3", "walk held", int'(walk_req_valid), 1);
            fill_valid = 1'b1;
            fill_vpn   = 13'(vpn);
            fill_ppn   = 13'(pmap(vpn));
            @(negedge clk);
            fill_valid = 1'b0;
            chk("R3", "req_ready after fill", int'(req_ready), 1);
            chk("R3", "walk dropped after fill", int'(walk_req_valid), 0);
            if (vpn < 256) mapped[vpn] = 1'b1;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog R3: actual=hung expected=complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int lv, v, k, seed;
        seed = $urandom(32'd20240611);
        for (int i = 0; i < 256; i++) mapped[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", "req_ready after reset", int'(req_ready), 1);
        chk("R10", "resp_valid after reset", int'(resp_valid), 0);
        chk("R10", "walk_req_valid after reset", int'(walk_req_valid), 0);

        access(5, 3, "R2", lv);
        access(5, 0, "R2", lv);
        access(5, 0, "R1", lv);
        access(4, 3, "R1", lv);
        access(4, 0, "R1", lv);

        @(negedge clk);
        fill_valid = 1'b1;
        fill_vpn   = 13'd77;
        fill_ppn   = 13'(pmap(77));
        @(negedge clk);
        fill_valid = 1'b0;
        chk("R9", "no walk after stray fill", int'(walk_req_valid), 0);
        access(77, 3, "R9", lv);

        do_flush();
        access(5, 3, "R8", lv);
        access(77, 3, "R8", lv);

        do_flush();
        for (int i = 0; i < 16; i++) access(i, 3, "R4", lv);
        access(16, 3, "R4", lv);
        access(0, 1, "R4", lv);
        access(0, 0, "R5", lv);
        access(1, 1, "R4", lv);
        access(1, 0, "R5", lv);

        do_flush();
        for (int i = 0; i < 9; i++) access(8 * i, 3, "R6", lv);
        for (int i = 0; i < 8; i++) begin
            access(8 * i + 1, 3, "R6", lv);
            access(8 * i + 2, 3, "R6", lv);
        end
        access(0, 2, "R6", lv);
        access(0, 0, "R6", lv);
        access(32, 2, "R6", lv);
        access(16, 2, "R6", lv);
        access(8, 1, "R6", lv);

        do_flush();
        for (int i = 0; i < 17; i++) access(8 * i + 3, 3, "R7", lv);
        access(3, 3, "R7", lv);

        do_flush();
        access(9, 3, "R8", lv);
        do_flush();
        access(9, 3, "R8", lv);

        for (int it = 0; it < 300; it++) begin
            if (($urandom % 40) == 0) do_flush();
            k = $urandom % 12;
            v = 8 * k + ($urandom % 2);
            if (!mapped[v]) begin
                access(v, 3, "R8", lv);
                access(v, 0, "R2", lv);
            end else begin
                access(v, -1, "R2", lv);
                if (lv == 3) access(v, 0, "R2", lv);
            end
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule